// File: doc/BRIEF.md
# Row Line-Buffer DMA Engine

This engine copies rectangles of image rows between the per-lane local memories of a SIMD lane array and a narrow external memory stream. A row buffer made of `GROUPS` parallel-load shift registers, each `SEG_W` bits wide and each covering one group of adjacent lanes, holds one complete row. The engine trades a whole row with the local memories in one stolen array memory cycle. It then streams the row to or from the external side one segment per beat, and the lanes keep running during the stream.

A request gives a transfer direction, a first local row, a row count, an external word address and an external row pitch. The rectangle spans the full array width and `nrows` consecutive local rows. Local row `row+i` maps to external words `ext + i*pitch + k`, with k from 0 to `GROUPS-1`. Requests go into one of two queues of `QDEPTH` entries each. The engine serves the high queue first, but it finishes the request in flight before it starts another.

Top module: `rowdma`

## Requirements
- R1: Each queue holds `QDEPTH` (32) entries. `q_full[1]` (high queue) and `q_full[0]` (low queue) are high exactly while that queue holds 32 entries. A request offered to a full queue is dropped and never executed.
- R2: When the engine is idle and both queues hold entries, the oldest entry of the high queue (`req_hi=1`) runs before any low-queue entry. Within one queue, requests run in arrival order.
- R3: A request that has started runs all of its rows before the next request begins, even if a high-priority request arrives meanwhile.
- R4: A store (`req_load=0`) handles each row in this order. First comes one local read (`mem_we=0`). Then come `GROUPS` (16) external beats with `ext_write=1`. Beat k carries row bits `[k*64 +: 64]`, which are lanes 8k..8k+7 with the lowest lane in the lowest byte.
- R5: A load (`req_load=1`) handles each row in this order. First come 16 external beats with `ext_write=0`, where `ext_rdata` is taken at each beat handshake. Then comes one local write (`mem_we=1`) whose `mem_wdata[k*64 +: 64]` is the data of beat k.
- R6: Each row takes exactly one granted local access, at `mem_row = row+i`. `mem_req` and its row and direction stay unchanged until `mem_gnt`. Read data is taken from `mem_rdata` one cycle after the granted read.
- R7: For row i of a request, beat k uses `ext_addr = ext + i*pitch + k`. Within a row, accepted beats step the address by one.
- R8: A beat completes when `ext_valid` and `ext_ready` are both high. While `ext_ready` is low, `ext_valid`, `ext_addr` and the write data stay unchanged. With `ext_ready` held high, the 16 beats of a row occupy 16 consecutive cycles.
- R9: `done` is high for one cycle, in the cycle after the last action of a request. For a store that is the final beat; for a load it is the final granted write.
- R10: A request with `nrows=0` raises `done` one cycle after it is taken from its queue and makes no memory or external access.
- R11: After reset, `done`, `mem_req`, `ext_valid` and both full flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Offer a request this cycle |
| req_hi | input | 1 | 1 = high queue, 0 = low queue |
| req_load | input | 1 | 1 = external to local, 0 = local to external |
| req_row | input | ROW_AW | First local row |
| req_nrows | input | CNT_W | Number of rows |
| req_ext | input | EXT_AW | External word address of the first row |
| req_pitch | input | PITCH_W | External words between rows |
| q_full | output | 2 | Queue full flags, bit 1 = high queue |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Local memory cycle wanted |
| mem_we | output | 1 | 1 = write row, 0 = read row |
| mem_row | output | ROW_AW | Local row address |
| mem_wdata | output | LANES*LANE_W | Row written to the local memories |
| mem_rdata | input | LANES*LANE_W | Row read, valid one cycle after grant |
| mem_gnt | input | 1 | Array yields its memory cycle |
| ext_valid | output | 1 | Beat offered |
| ext_write | output | 1 | 1 = beat writes external memory |
| ext_addr | output | EXT_AW | External word address of the beat |
| ext_wdata | output | SEG_W | Write beat data |
| ext_rdata | input | SEG_W | Read beat data, taken at handshake |
| ext_ready | input | 1 | External side accepts the beat |

## Verification
The bench queues three requests of mixed direction behind a stalled store and expects the high-priority one to run next. An engine that ignored priority, or served requests in the wrong order, would show a mismatch in the event stream. A high-priority request that arrives in the middle of a three-row load must wait; an engine that preempted it would interleave rows. The bench stalls grants and ready with irregular patterns and checks that beats hold their address and data and that segments land in the right 64-bit lanes. A reversed shift direction or a misaligned row would put lane groups in swapped positions. The bench also fills the low queue to 32 entries and then offers one more: a design that overflowed its queue would complete one extra request. Zero-row requests must finish with no memory or external traffic.

// File: rtl/rowdma.sv
module rowdma #(
  parameter int LANES   = 128,
  parameter int LANE_W  = 8,
  parameter int GROUPS  = 16,
  parameter int QDEPTH  = 32,
  parameter int ROW_AW  = 8,
  parameter int CNT_W   = 9,
  parameter int EXT_AW  = 24,
  parameter int PITCH_W = 16,
  localparam int ROW_BITS = LANES * LANE_W,
  localparam int SEG_W    = ROW_BITS / GROUPS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_hi,
  input  logic                req_load,
  input  logic [ROW_AW-1:0]   req_row,
  input  logic [CNT_W-1:0]    req_nrows,
  input  logic [EXT_AW-1:0]   req_ext,
  input  logic [PITCH_W-1:0]  req_pitch,
  output logic [1:0]          q_full,
  output logic                done,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ROW_AW-1:0]   mem_row,
  output logic [ROW_BITS-1:0] mem_wdata,
  input  logic [ROW_BITS-1:0] mem_rdata,
  input  logic                mem_gnt,
  output logic                ext_valid,
  output logic                ext_write,
  output logic [EXT_AW-1:0]   ext_addr,
  output logic [SEG_W-1:0]    ext_wdata,
  input  logic [SEG_W-1:0]    ext_rdata,
  input  logic                ext_ready
);
  localparam int QPW   = $clog2(QDEPTH);
  localparam int BW    = $clog2(GROUPS);
  localparam int ENT_W = 1 + ROW_AW + CNT_W + EXT_AW + PITCH_W;
  localparam logic [QPW:0]  QCAP  = (QPW+1)'(QDEPTH);
  localparam logic [BW-1:0] LASTB = BW'(GROUPS - 1);

  typedef enum logic [2:0] {S_IDLE, S_MRD, S_MCAP, S_SHIFT, S_MWR} st_t;

  logic [ENT_W-1:0] qmem [2][QDEPTH];
  logic [QPW-1:0]   wp [2];
  logic [QPW-1:0]   rp [2];
  logic [QPW:0]     cnt [2];
  logic [1:0]       push, pop;
  logic [ENT_W-1:0] ent_in, head;

  logic               h_load;
  logic [ROW_AW-1:0]  h_row;
  logic [CNT_W-1:0]   h_n;
  logic [EXT_AW-1:0]  h_ext;
  logic [PITCH_W-1:0] h_pitch;

  st_t                st;
  logic               cur_load;
  logic [ROW_AW-1:0]  cur_row;
  logic [CNT_W-1:0]   left;
  logic [EXT_AW-1:0]  row_ext;
  logic [PITCH_W-1:0] cur_pitch;
  logic [BW-1:0]      beat;
  logic [SEG_W-1:0]   sr [GROUPS];
  logic               last_row;

  assign ent_in  = {req_load, req_row, req_nrows, req_ext, req_pitch};
  assign push[1] = req_valid &&  req_hi && !q_full[1];
  assign push[0] = req_valid && !req_hi && !q_full[0];
  assign pop[1]  = (st == S_IDLE) && (cnt[1] != '0);
  assign pop[0]  = (st == S_IDLE) && (cnt[1] == '0) && (cnt[0] != '0);
  assign head    = pop[1] ? qmem[1][rp[1]] : qmem[0][rp[0]];
  assign {h_load, h_row, h_n, h_ext, h_pitch} = head;

  for (genvar g = 0; g < 2; g++) begin : g_full
    assign q_full[g] = (cnt[g] == QCAP);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < 2; i++)
      if (push[i]) qmem[i][wp[i]] <= ent_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        wp[i] <= '0; rp[i] <= '0; cnt[i] <= '0;
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (push[i]) wp[i] <= wp[i] + 1'b1;
        if (pop[i])  rp[i] <= rp[i] + 1'b1;
        cnt[i] <= cnt[i] + {{QPW{1'b0}}, push[i]} - {{QPW{1'b0}}, pop[i]};
      end
    end
  end

  assign last_row = (left == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; done <= 1'b0; cur_load <= 1'b0; cur_row <= '0;
      left <= '0; row_ext <= '0; cur_pitch <= '0; beat <= '0;
      for (int g = 0; g < GROUPS; g++) sr[g] <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (pop != 2'b00) begin
          cur_load <= h_load; cur_row <= h_row; left <= h_n;
          row_ext <= h_ext; cur_pitch <= h_pitch; beat <= '0;
          if (h_n == '0) done <= 1'b1;
          else st <= h_load ? S_SHIFT : S_MRD;
        end
        S_MRD: if (mem_gnt) st <= S_MCAP;
        S_MCAP: begin
          for (int g = 0; g < GROUPS; g++) sr[g] <= mem_rdata[g*SEG_W +: SEG_W];
          st <= S_SHIFT;
        end
        S_SHIFT: if (ext_ready) begin
          for (int g = 0; g < GROUPS-1; g++) sr[g] <= sr[g+1];
          sr[GROUPS-1] <= cur_load ? ext_rdata : '0;
          beat <= (beat == LASTB) ? '0 : beat + 1'b1;
          if (beat == LASTB) begin
            if (cur_load) st <= S_MWR;
            else if (last_row) begin done <= 1'b1; st <= S_IDLE; end
            else begin
              left <= left - 1'b1; cur_row <= cur_row + 1'b1;
              row_ext <= row_ext + EXT_AW'(cur_pitch); st <= S_MRD;
            end
          end
        end
        S_MWR: if (mem_gnt) begin
          if (last_row) begin done <= 1'b1; st <= S_IDLE; end
          else begin
            left <= left - 1'b1; cur_row <= cur_row + 1'b1;
            row_ext <= row_ext + EXT_AW'(cur_pitch); st <= S_SHIFT;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_flat
    assign mem_wdata[g*SEG_W +: SEG_W] = sr[g];
  end

  assign mem_req   = (st == S_MRD) || (st == S_MWR);
  assign mem_we    = (st == S_MWR);
  assign mem_row   = cur_row;
  assign ext_valid = (st == S_SHIFT);
  assign ext_write = !cur_load;
  assign ext_addr  = row_ext + EXT_AW'(beat);
  assign ext_wdata = sr[0];

  a_r6_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_row) && $stable(mem_we));
  a_r8_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ext_valid && !ext_ready |=> ext_valid && $stable(ext_addr) && $stable(ext_write)
                                && (!ext_write || $stable(ext_wdata)));
  a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    ext_valid && ext_ready && (beat != LASTB) |=> ext_valid && (ext_addr == $past(ext_addr) + 1'b1));
  a_r4_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req, ext_valid}));
  a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req && !ext_valid);
endmodule

// File: tb/rowdma_tb_top.sv
`timescale 1ns/1ps
module rowdma_tb_top;
  localparam int RB = 1024;
  localparam int SW = 64;
  localparam int G  = 16;
  localparam logic [1:0] K_MRD = 2'd0, K_MWR = 2'd1, K_ER = 2'd2, K_EW = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_hi = 0, req_load = 0;
  logic [7:0] req_row = 0; logic [8:0] req_nrows = 0;
  logic [23:0] req_ext = 0; logic [15:0] req_pitch = 0;
  logic [1:0] q_full; logic done, mem_req, mem_we, mem_gnt = 1'b1;
  logic [7:0] mem_row; logic [RB-1:0] mem_wdata, mem_rdata = '0;
  logic ext_valid, ext_write, ext_ready = 1'b1;
  logic [23:0] ext_addr; logic [SW-1:0] ext_wdata, ext_rdata;

  always #2 clk = ~clk;

  rowdma dut_i (.clk, .rst_n, .req_valid, .req_hi, .req_load, .req_row, .req_nrows,
    .req_ext, .req_pitch, .q_full, .done, .mem_req, .mem_we, .mem_row, .mem_wdata,
    .mem_rdata, .mem_gnt, .ext_valid, .ext_write, .ext_addr, .ext_wdata, .ext_rdata, .ext_ready);

  function automatic logic [RB-1:0] lrow(input int row);
    logic [RB-1:0] v;
    for (int w = 0; w < RB/32; w++)
      v[w*32 +: 32] = {8'(row), 8'(w), 16'(row*97 + w*13) ^ 16'hBEEF};
    return v;
  endfunction
  function automatic logic [SW-1:0] ext_word(input logic [23:0] a);
    return {a, 8'hC3, ~a, 8'h5A};
  endfunction

  assign ext_rdata = ext_word(ext_addr);
  always @(posedge clk) if (mem_req && mem_gnt && !mem_we) mem_rdata <= lrow(int'(mem_row));

  typedef struct { logic [1:0] k; logic [31:0] a; logic [RB-1:0] d; bit last; logic [23:0] tag; } ev_t;
  ev_t sb[$];
  int checks = 0, fails = 0, done_cnt = 0, evn = 0, ncyc = 0;
  int beat_cyc[$];
  bit pend_done = 0, was_stall = 0, gnt_block = 0, gnt_pat = 0, rdy_pat = 0, finished = 0;
  logic [23:0] stall_addr; logic [SW-1:0] stall_data;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [RB-1:0] act, input logic [RB-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic handle(input logic [1:0] k, input logic [31:0] a, input logic [RB-1:0] d);
    ev_t e;
    evn++;
    if (sb.size() == 0) begin
      chk(0, "R3", "unexpected event kind", RB'(k), '1); return;
    end
    e = sb.pop_front();
    chk(k == e.k && a == e.a, string'(e.tag), "event kind/addr", RB'({k, a}), RB'({e.k, e.a}));
    if (k == K_MWR || k == K_EW) chk(d == e.d, string'(e.tag), "event data", d, e.d);
    if (e.last) pend_done = 1;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      ncyc++;
      mem_gnt   = !gnt_block && (!gnt_pat || (ncyc % 3 != 0));
      ext_ready = !rdy_pat || (ncyc % 4 != 1);
      if (rst_n) begin
        if (pend_done) begin chk(done == 1'b1, "R9", "done pulse", RB'(done), RB'(1)); pend_done = 0; end
        if (done) done_cnt++;
        if (was_stall)
          chk(ext_valid && ext_addr == stall_addr && (!ext_write || ext_wdata == stall_data),
              "R8", "beat held under stall", RB'({ext_valid, ext_addr}), RB'({1'b1, stall_addr}));
        was_stall = ext_valid && !ext_ready;
        stall_addr = ext_addr; stall_data = ext_wdata;
        if (mem_req && mem_gnt) handle(mem_we ? K_MWR : K_MRD, 32'(mem_row), mem_we ? mem_wdata : '0);
        if (ext_valid && ext_ready) begin
          beat_cyc.push_back(ncyc);
          handle(ext_write ? K_EW : K_ER, 32'(ext_addr), ext_write ? RB'(ext_wdata) : '0);
        end
      end
    end
  end

  task automatic exp_store(input int row, input int n, input int ext, input int pitch, input logic [23:0] tag);
    ev_t e;
    for (int r = 0; r < n; r++) begin
      e = '{K_MRD, 32'((row + r) % 256), '0, 0, tag}; sb.push_back(e);
      for (int k = 0; k < G; k++) begin
        e = '{K_EW, 32'(24'(ext + r*pitch + k)), RB'(lrow((row + r) % 256) >> (k*SW)) & RB'({SW{1'b1}}),
              (r == n-1 && k == G-1), tag};
        sb.push_back(e);
      end
    end
  endtask

  task automatic exp_load(input int row, input int n, input int ext, input int pitch, input logic [23:0] tag);
    ev_t e; logic [RB-1:0] d;
    for (int r = 0; r < n; r++) begin
      for (int k = 0; k < G; k++) begin
        e = '{K_ER, 32'(24'(ext + r*pitch + k)), '0, 0, tag}; sb.push_back(e);
        d[k*SW +: SW] = ext_word(24'(ext + r*pitch + k));
      end
      e = '{K_MWR, 32'((row + r) % 256), d, (r == n-1), tag}; sb.push_back(e);
    end
  endtask

  task automatic sub(input bit load, input bit hi, input int row, input int n, input int ext, input int pitch);
    @(negedge clk);
    req_valid = 1; req_load = load; req_hi = hi; req_row = 8'(row);
    req_nrows = 9'(n); req_ext = 24'(ext); req_pitch = 16'(pitch);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    repeat (40) @(negedge clk);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "R3", "watchdog expired", '0, '1);
    report();
  end

  initial begin
    int base, ev0;
    repeat (3) @(negedge clk);
    chk(done == 0 && mem_req == 0 && ext_valid == 0 && q_full == 2'b00, "R11", "reset state",
        RB'({done, mem_req, ext_valid, q_full}), '0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R4 R6 R8: single store row, no stalls, beats back to back
    exp_store(5, 1, 'h100, 0, "R4");
    beat_cyc.delete();
    sub(0, 0, 5, 1, 'h100, 0);
    drain();
    chk(beat_cyc.size() == G && beat_cyc[G-1] - beat_cyc[0] == G-1, "R8", "consecutive beats",
        RB'(beat_cyc[G-1] - beat_cyc[0]), RB'(G-1));

    // R5 R7: two-row load with pitch
    exp_load(20, 2, 'h2000, 40, "R5");
    sub(1, 1, 20, 2, 'h2000, 40);
    drain();

    // R7 R8 R6: three-row store under grant and ready stalls
    gnt_pat = 1; rdy_pat = 1;
    exp_store(254, 3, 'h3F0, 100, "R7");
    sub(0, 0, 254, 3, 'h3F0, 100);
    drain();
    gnt_pat = 0; rdy_pat = 0;

    // R2: high queue first, low queue in order
    gnt_block = 1;
    exp_store(1, 1, 'h10, 0, "R2");
    exp_load(40, 1, 'h500, 0, "R2");
    exp_load(30, 1, 'h400, 0, "R2");
    exp_store(31, 1, 'h600, 0, "R2");
    sub(0, 0, 1, 1, 'h10, 0);
    repeat (3) @(negedge clk);
    sub(1, 0, 30, 1, 'h400, 0);
    sub(0, 0, 31, 1, 'h600, 0);
    sub(1, 1, 40, 1, 'h500, 0);
    repeat (3) @(negedge clk);
    gnt_block = 0;
    drain();

    // R3: high request arriving mid-transfer waits
    exp_load(60, 3, 'h800, 16, "R3");
    exp_store(70, 1, 'h900, 0, "R3");
    sub(1, 0, 60, 3, 'h800, 16);
    ev0 = evn;
    while (evn < ev0 + G + 1) @(negedge clk);
    sub(0, 1, 70, 1, 'h900, 0);
    drain();

    // R10: zero-row request
    base = done_cnt; ev0 = evn;
    sub(0, 1, 9, 0, 'h0, 0);
    repeat (10) @(negedge clk);
    chk(done_cnt == base + 1, "R10", "zero-row done count", RB'(done_cnt - base), RB'(1));
    chk(evn == ev0, "R10", "zero-row traffic", RB'(evn - ev0), '0);

    // R1: fill the low queue, offer one extra
    gnt_block = 1;
    exp_store(3, 1, 'h30, 0, "R1");
    sub(0, 0, 3, 1, 'h30, 0);
    repeat (3) @(negedge clk);
    base = done_cnt;
    for (int i = 0; i < 32; i++) sub(0, 0, i, 0, 0, 0);
    chk(q_full == 2'b01, "R1", "low queue full", RB'(q_full), RB'(2'b01));
    sub(1, 0, 99, 0, 0, 0);
    chk(q_full == 2'b01, "R1", "full after drop", RB'(q_full), RB'(2'b01));
    gnt_block = 0;
    drain();
    chk(done_cnt == base + 33, "R1", "completions after overflow", RB'(done_cnt - base), RB'(33));
    chk(q_full == 2'b00, "R1", "queues empty", RB'(q_full), '0);

    report();
  end
endmodule